// File: doc/BRIEF.md
# Spread-Pulse PWM Digital-to-Analog Generator

This block turns a RES_W-bit code into a single pulse-width-modulated pin whose average, once low-pass filtered outside the chip, tracks the code with full resolution. One conversion cycle lasts 2^RES_W clock ticks. It is cut into equal base pulses, each with the same coarse high width. The remaining low-order code bits add one extra tick of high time to a chosen subset of base pulses. That subset is spread evenly over the cycle, so the ripple stays at the base-pulse rate and not at the conversion rate.

Two base-pulse lengths are selectable with each write: a long base of 2^LONG_W ticks and a short base of 2^SHORT_W ticks. Writes land in a holding register and reach the working copy only at a conversion-cycle boundary, or at once while the block is disabled. A live polarity input swaps which phase carries the programmed width.

Top module: `spread_pwm_dac`

## Requirements
- R1: While reset is asserted, `pwm_o` is 0 and the tick counter is 0.
- R2: With the long base selected (`wr_long_i` = 1 at write), a base pulse is 2^LONG_W ticks, the coarse width is code bits [RES_W-1:RES_W-LONG_W], and the fine field is the low RES_W-LONG_W bits.
- R3: With the short base selected (`wr_long_i` = 0), a base pulse is 2^SHORT_W ticks, the coarse width is code bits [RES_W-1:RES_W-SHORT_W], and the fine field is the low RES_W-SHORT_W bits.
- R4: In every base pulse the active phase starts at the first tick of the pulse and lasts the coarse width; ticks at or beyond coarse width plus extra are inactive.
- R5: Base pulse p (0-based, N pulses, NB = log2 N fine bits) gets one extra active tick, placed right after the coarse width, when j = (p + N/2 + 2) mod N is non-zero, z is the count of trailing zero bits of j, and fine bit NB-1-z is 1. Fine bit 0 thus marks pulse N-1 (1-based) only.
- R6: Over a whole conversion cycle the number of active ticks equals the code value.
- R7: With `inv_i` = 1 the pin shows the inverse of the active phase, so high ticks per cycle equal 2^RES_W minus the code.
- R8: A write during an enabled cycle leaves that cycle unchanged and governs the next cycle from its first tick.
- R9: While `en_i` = 0 the pin sits at the level of `inv_i` and the counter is 0; after enable the cycle restarts at tick 0.
- R10: A write made while disabled governs the first cycle after enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Resolution clock, one tick per edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds counter and idles the pin |
| inv_i | input | 1 | Polarity: 1 puts the programmed width on the low phase |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_long_i | input | 1 | Base length select stored with the code (1 long, 0 short) |
| wr_data_i | input | RES_W | Code to convert |
| pwm_o | output | 1 | Modulated output pin, registered |

## Verification
The bench builds the block with RES_W = 8, LONG_W = 5 and SHORT_W = 3, so a conversion cycle is 256 ticks with 8 long or 32 short base pulses. This keeps every cycle short enough to compare tick by tick against a model, while both fine-field widths (3 and 5 bits) still exercise the full insertion spread, the all-ones and all-zeros codes, zero coarse width with only inserted ticks, and saturation where an extra tick fills a whole base pulse.

// File: rtl/spread_pwm_dac.sv
module spread_pwm_dac #(
  parameter int RES_W   = 14,
  parameter int LONG_W  = 8,
  parameter int SHORT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             inv_i,
  input  logic             wr_i,
  input  logic             wr_long_i,
  input  logic [RES_W-1:0] wr_data_i,
  output logic             pwm_o
);

  localparam int LNB = RES_W - LONG_W;
  localparam int SNB = RES_W - SHORT_W;
  localparam int PW  = SNB;
  localparam logic [RES_W-1:0] CNT_MAX = '1;

  logic [RES_W-1:0] cnt_q, buf_q, act_q;
  logic             buf_long_q, act_long_q, pwm_q;

  logic [RES_W-1:0] buf_d;
  logic             buf_long_d;
  assign buf_d      = wr_i ? wr_data_i : buf_q;
  assign buf_long_d = wr_i ? wr_long_i : buf_long_q;

  function automatic logic ins_hit(input logic [PW-1:0] p, input logic [PW-1:0] fine, input int nb);
    logic [PW-1:0] j, msk;
    logic hit, found;
    msk   = (PW'(1) << nb) - PW'(1);
    j     = (p + (PW'(1) << (nb - 1)) + PW'(2)) & msk;
    hit   = 1'b0;
    found = 1'b0;
    for (int z = 0; z < PW; z++) begin
      if (z < nb && !found && j[z]) begin
        hit   = fine[nb-1-z];
        found = 1'b1;
      end
    end
    return hit;
  endfunction

  logic [LONG_W-1:0]  t_long, c_long;
  logic [SHORT_W-1:0] t_short, c_short;
  logic [LNB-1:0]     p_long, f_long;
  logic [SNB-1:0]     p_short, f_short;
  logic               hit_long, hit_short, on_long, on_short, on_now;

  assign t_long  = cnt_q[LONG_W-1:0];
  assign p_long  = cnt_q[RES_W-1:LONG_W];
  assign c_long  = act_q[RES_W-1:LNB];
  assign f_long  = act_q[LNB-1:0];
  assign t_short = cnt_q[SHORT_W-1:0];
  assign p_short = cnt_q[RES_W-1:SHORT_W];
  assign c_short = act_q[RES_W-1:SNB];
  assign f_short = act_q[SNB-1:0];

  assign hit_long  = ins_hit(PW'(p_long), PW'(f_long), LNB);
  assign hit_short = ins_hit(p_short, f_short, SNB);

  assign on_long  = {1'b0, t_long}  < ({1'b0, c_long}  + (LONG_W+1)'(hit_long));
  assign on_short = {1'b0, t_short} < ({1'b0, c_short} + (SHORT_W+1)'(hit_short));
  assign on_now   = act_long_q ? on_long : on_short;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      buf_q      <= '0;
      buf_long_q <= 1'b0;
      act_q      <= '0;
      act_long_q <= 1'b0;
      pwm_q      <= 1'b0;
    end else begin
      buf_q      <= buf_d;
      buf_long_q <= buf_long_d;
      if (!en_i || cnt_q == CNT_MAX) begin
        act_q      <= buf_d;
        act_long_q <= buf_long_d;
      end
      cnt_q <= en_i ? cnt_q + 1'b1 : '0;
      pwm_q <= en_i ? (on_now ^ inv_i) : inv_i;
    end
  end

  assign pwm_o = pwm_q;

  a_r8_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && $past(cnt_q) != CNT_MAX) |-> ($stable(act_q) && $stable(act_long_q)));

  a_r9_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pwm_o == $past(inv_i) && cnt_q == '0));

  a_r2_cycle_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q == CNT_MAX) |=> cnt_q == '0);

  a_r4_head_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && act_long_q && t_long < c_long) |=> pwm_o != $past(inv_i));

  a_r4_tail_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && act_long_q && {1'b0, t_long} > {1'b0, c_long}) |=> pwm_o == $past(inv_i));

  a_r3_short_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !act_long_q && t_short < c_short) |=> pwm_o != $past(inv_i));

  always_comb begin
    if (!rst_ni) a_r1_reset_low: assert (pwm_q == 1'b0 && cnt_q == '0);
  end

endmodule

// File: tb/spread_pwm_dac_tb.sv
module spread_pwm_dac_tb;

  localparam int RW = 8;
  localparam int LW = 5;
  localparam int SW = 3;
  localparam int TICKS = 1 << RW;
  localparam int NVEC = 8;

  // {long, inv, code}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'd17},
    {1'b1, 1'b0, 8'hFF},
    {1'b0, 1'b0, 8'h00},
    {1'b0, 1'b0, 8'hA5},
    {1'b1, 1'b1, 8'h5C},
    {1'b0, 1'b1, 8'h1F},
    {1'b1, 1'b0, 8'h07},
    {1'b0, 1'b0, 8'hE0}
  };

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, inv = 1'b0, wr = 1'b0, wr_long = 1'b0;
  logic [RW-1:0] wr_data = '0;
  logic pwm;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  spread_pwm_dac #(.RES_W(RW), .LONG_W(LW), .SHORT_W(SW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .inv_i(inv), .wr_i(wr),
    .wr_long_i(wr_long), .wr_data_i(wr_data), .pwm_o(pwm)
  );

  function automatic logic exp_on(input logic lng, input int code, input int c);
    int bw, nb, n, t, p, coarse, fine, j, z, extra;
    bw = lng ? LW : SW;
    nb = RW - bw;
    n = 1 << nb;
    t = c % (1 << bw);
    p = c >> bw;
    coarse = code >> nb;
    fine = code % n;
    j = (p + n / 2 + 2) % n;
    extra = 0;
    if (j != 0) begin
      z = 0;
      while (((j >> z) & 1) == 0) z++;
      extra = (fine >> (nb - 1 - z)) & 1;
    end
    return t < coarse + extra;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_cycle(input logic lng, input logic iv, input int code, input int wr_at,
                           input logic [9:0] nxt, input string req);
    int mism = 0, hi = 0;
    for (int c = 0; c < TICKS; c++) begin
      @(negedge clk);
      if (c == wr_at) begin
        wr = 1'b1; wr_long = nxt[9]; wr_data = nxt[7:0];
      end
      if (c == wr_at + 1) wr = 1'b0;
      if (pwm !== (exp_on(lng, code, c) ^ iv)) mism++;
      if (pwm === 1'b1) hi++;
    end
    chk(mism == 0, req, "ticks differing from model (R4 R5 R8)", mism, 0);
    chk(hi == (iv ? TICKS - code : code), iv ? "R6 R7" : "R6", "high ticks per cycle", hi, iv ? TICKS - code : code);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int p0, p6;
    repeat (3) @(negedge clk);
    chk(pwm == 1'b0, "R1", "pwm during reset", pwm, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pwm == 1'b0, "R1", "pwm after reset, idle", pwm, 0);

    wr = 1'b1; wr_long = VEC[0][9]; wr_data = VEC[0][7:0];
    @(negedge clk);
    wr = 1'b0; en = 1'b1; inv = VEC[0][8];

    for (int v = 0; v < NVEC; v++) begin
      inv = VEC[v][8];
      run_cycle(VEC[v][9], VEC[v][8], int'(VEC[v][7:0]), (v < NVEC - 1) ? 100 : -5,
                VEC[(v + 1) % NVEC], VEC[v][9] ? "R2" : "R3");
    end

    // disable: pin idles at inv level
    en = 1'b0; inv = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(pwm == 1'b1, "R9", "idle level with inv=1", pwm, 1);
      if (k == 1) begin wr = 1'b1; wr_long = 1'b1; wr_data = 8'd17; end
      if (k == 2) wr = 1'b0;
    end
    inv = 1'b0;
    @(negedge clk);
    chk(pwm == 1'b0, "R9", "idle level with inv=0", pwm, 0);

    // write done while disabled governs first cycle (R10); check insertion position (R5)
    en = 1'b1;
    p0 = 0; p6 = 0;
    for (int c = 0; c < TICKS; c++) begin
      @(negedge clk);
      if (pwm && (c >> LW) == 0) p0++;
      if (pwm && (c >> LW) == 6) p6++;
    end
    chk(p0 == 2, "R10", "base pulse 0 high ticks, code 17", p0, 2);
    chk(p6 == 3, "R5", "base pulse 6 high ticks with fine bit 0", p6, 3);

    // mid-cycle disable restarts at tick 0
    for (int c = 0; c < 50; c++) @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    en = 1'b1;
    run_cycle(1'b1, 1'b0, 17, -5, 10'd0, "R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule